// File: doc/BRIEF.md
# Deflection Side Buffer with Timed Redirection

This block sits beside a deflection router and holds a few flits that would otherwise be sent the wrong way. Each cycle it looks at the router's output lanes after arbitration. From the lanes that carry a deflected flit, it may take one and remove it from the output, storing it in a small first-in first-out queue. When the router's input pipeline has an empty slot, the oldest buffered flit is put back into that slot so it can compete again. Flits of the globally prioritised packet are never taken in.

A buffered flit could wait forever if the input pipeline stays full. To prevent this, the block counts how long the head flit has waited. Once the count reaches a threshold and every input slot is still occupied, the block swaps one input flit with the head. It picks a non-golden input slot, starting from a pseudo-random slot index, and pushes that flit into the queue. The head flit goes into the freed slot. Occupancy does not change during a swap. All slot changes are combinational within the cycle. Only the queue, the wait counter and the random generator are registered.

Top module: `defl_side_buf`

## Requirements
- R1: In one cycle at most one output lane is captured. The captured lane is the lowest-index lane whose valid and deflect flags are both set and whose golden flag is clear. Its valid bit is cleared on `out_vld_o`. Every other output lane passes through unchanged.
- R2: No lane is captured when the occupancy at the start of the cycle equals `BUF_DEPTH` (default 4). The output lanes then pass through unchanged.
- R3: A golden flit is never taken into the buffer, either from an output lane or from an input slot during a swap.
- R4: Buffered flits leave the queue in the order they entered it.
- R5: When the queue is non-empty and at least one input slot is empty (valid clear), the head flit is placed into the lowest-index empty slot, and that slot's valid bit is set. An occupied input slot is never emptied.
- R6: The wait counter is zero after reset. It is zero in the cycle after a cycle in which the queue was empty or the head left. Otherwise it rises by one per cycle and saturates at `REDIR_WAIT` (default 2).
- R7: A swap happens when the queue is non-empty, all input slots are valid, the wait counter equals `REDIR_WAIT`, and at least one input slot is not golden. The flit in the chosen slot is pushed into the queue and the head flit replaces it. No output lane is captured in a swap cycle.
- R8: The swap slot is the first non-golden slot found by scanning upward with wrap-around. The scan starts at index (L mod `NUM_PORTS`), where L is an 8-bit register. L is 8'hA5 after reset and advances on every clock edge out of reset to {L[6:0], L[7]^L[5]^L[4]^L[3]}.
- R9: After reset the queue is empty, so every output lane and every input slot passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_vld_i | input | NUM_PORTS | Output lane valid flags after arbitration |
| out_defl_i | input | NUM_PORTS | Output lane deflected flags |
| out_gold_i | input | NUM_PORTS | Output lane golden flags |
| out_flit_i | input | NUM_PORTS*FLIT_W | Output lane flits, lane i at bits [i*FLIT_W +: FLIT_W] |
| in_vld_i | input | NUM_PORTS | Input slot valid flags |
| in_gold_i | input | NUM_PORTS | Input slot golden flags |
| in_flit_i | input | NUM_PORTS*FLIT_W | Input slot flits |
| out_vld_o | output | NUM_PORTS | Output lane valid flags after capture |
| out_flit_o | output | NUM_PORTS*FLIT_W | Output lane flits (unchanged) |
| in_vld_o | output | NUM_PORTS | Input slot valid flags after re-injection |
| in_flit_o | output | NUM_PORTS*FLIT_W | Input slot flits after re-injection or swap |

## Verification
The assertions assume that a flag is meaningful only on a lane whose valid bit is set. They also assume that a golden flag marks a flit the router must not lose, so the checks tie golden lanes and golden slots to unchanged contents. The stimulus allows any mix of flags, including input vectors that are entirely golden and full. That case is legal and simply blocks any swap, which lets the full-queue phase run without redirection getting in the way. Directed phases set up the capture priority, the full queue, the drain order and several swaps with golden slots placed around the random start point. A long random phase then mixes all of these.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int LFSR_W = 8;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction
endpackage

// File: rtl/sb_pick.sv
module sb_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(start) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/sb_lfsr.sv
module sb_lfsr #(
    parameter logic [sb_pkg::LFSR_W-1:0] SEED = 8'hA5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [sb_pkg::LFSR_W-1:0] value
);
    typedef struct packed {
        logic [sb_pkg::LFSR_W-1:0] lfsr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lfsr = sb_pkg::lfsr_step(st_q.lfsr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lfsr: SEED};
        else        st_q <= st_d;
    end

    assign value = st_q.lfsr;
endmodule

// File: rtl/sb_fifo.sv
module sb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({push, pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr_ptr] <= push_data;
    end

    assign head  = mem_q[st_q.rd_ptr];
    assign empty = (st_q.count == '0);
    assign full  = (st_q.count == CW'(DEPTH));

    // R2: a push into a full queue must be matched by a pop in the same cycle
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R4: the head is read only when something is stored
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/defl_side_buf.sv
module defl_side_buf #(
    parameter int NUM_PORTS  = 4,
    parameter int FLIT_W     = 16,
    parameter int BUF_DEPTH  = 4,
    parameter int REDIR_WAIT = 2,
    parameter logic [7:0] LFSR_SEED = 8'hA5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          out_vld_i,
    input  logic [NUM_PORTS-1:0]          out_defl_i,
    input  logic [NUM_PORTS-1:0]          out_gold_i,
    input  logic [NUM_PORTS*FLIT_W-1:0]   out_flit_i,
    input  logic [NUM_PORTS-1:0]          in_vld_i,
    input  logic [NUM_PORTS-1:0]          in_gold_i,
    input  logic [NUM_PORTS*FLIT_W-1:0]   in_flit_i,
    output logic [NUM_PORTS-1:0]          out_vld_o,
    output logic [NUM_PORTS*FLIT_W-1:0]   out_flit_o,
    output logic [NUM_PORTS-1:0]          in_vld_o,
    output logic [NUM_PORTS*FLIT_W-1:0]   in_flit_o
);
    localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int WAIT_W = $clog2(REDIR_WAIT + 1);

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
    } sb_st_t;

    sb_st_t st_d, st_q;

    logic [sb_pkg::LFSR_W-1:0] rnd;
    logic [IDX_W-1:0] rnd_start;
    logic [FLIT_W-1:0] head, push_data;
    logic empty, full, push, pop;
    logic cap_found, free_found, swap_found;
    logic [IDX_W-1:0] cap_idx, free_idx, swap_idx;
    logic do_swap, do_reinj, do_cap;

    sb_lfsr #(.SEED(LFSR_SEED)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(rnd));

    assign rnd_start = IDX_W'(32'(rnd) % NUM_PORTS);

    sb_pick #(.N(NUM_PORTS)) u_pick_cap (
        .req(out_vld_i & out_defl_i & ~out_gold_i), .start('0),
        .found(cap_found), .idx(cap_idx));
    sb_pick #(.N(NUM_PORTS)) u_pick_free (
        .req(~in_vld_i), .start('0),
        .found(free_found), .idx(free_idx));
    sb_pick #(.N(NUM_PORTS)) u_pick_swap (
        .req(in_vld_i & ~in_gold_i), .start(rnd_start),
        .found(swap_found), .idx(swap_idx));

    sb_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .empty(empty), .full(full));

    always_comb begin
        st_d       = st_q;
        do_swap    = !empty && !free_found && swap_found
                     && (st_q.wait_cnt == WAIT_W'(REDIR_WAIT));
        do_reinj   = !empty && free_found;
        do_cap     = !do_swap && cap_found && !full;
        pop        = do_swap || do_reinj;
        push       = do_swap || do_cap;
        push_data  = do_swap ? in_flit_i[swap_idx*FLIT_W +: FLIT_W]
                             : out_flit_i[cap_idx*FLIT_W +: FLIT_W];

        out_vld_o  = out_vld_i;
        out_flit_o = out_flit_i;
        if (do_cap) out_vld_o[cap_idx] = 1'b0;

        in_vld_o   = in_vld_i;
        in_flit_o  = in_flit_i;
        if (do_swap) begin
            in_flit_o[swap_idx*FLIT_W +: FLIT_W] = head;
        end else if (do_reinj) begin
            in_vld_o[free_idx]                   = 1'b1;
            in_flit_o[free_idx*FLIT_W +: FLIT_W] = head;
        end

        if (empty || pop)
            st_d.wait_cnt = '0;
        else if (st_q.wait_cnt != WAIT_W'(REDIR_WAIT))
            st_d.wait_cnt = st_q.wait_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: at most one output lane loses its flit per cycle, none gains one
    assert_single_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_vld_i & ~out_vld_o) <= 1) && ((out_vld_o & ~out_vld_i) == '0));

    // R7: a swap cycle (all slots full, head leaves) never captures an output lane
    assert_swap_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (&in_vld_i)) |-> (out_vld_o == out_vld_i));

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
            // R3: golden output lanes keep their flit
            assert_gold_out_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_vld_i[g] && out_gold_i[g]) |-> out_vld_o[g]);
            // R3: golden input slots keep their flit
            assert_gold_in_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld_i[g] && in_gold_i[g]) |->
                (in_flit_o[g*FLIT_W +: FLIT_W] == in_flit_i[g*FLIT_W +: FLIT_W]));
            // R5: occupied input slots are never emptied
            assert_slot_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld_i[g] |-> in_vld_o[g]);
        end
    endgenerate
endmodule

// File: tb/defl_side_buf_bench.sv
module defl_side_buf_bench;
    localparam int N = 4;
    localparam int W = 16;
    localparam int D = 4;
    localparam int T = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   out_vld_i = '0, out_defl_i = '0, out_gold_i = '0;
    logic [N*W-1:0] out_flit_i = '0;
    logic [N-1:0]   in_vld_i = '0, in_gold_i = '0;
    logic [N*W-1:0] in_flit_i = '0;
    logic [N-1:0]   out_vld_o, in_vld_o;
    logic [N*W-1:0] out_flit_o, in_flit_o;

    always #4 clk = ~clk;

    defl_side_buf u_defl_side_buf (
        .clk(clk), .rst_n(rst_n),
        .out_vld_i(out_vld_i), .out_defl_i(out_defl_i), .out_gold_i(out_gold_i),
        .out_flit_i(out_flit_i), .in_vld_i(in_vld_i), .in_gold_i(in_gold_i),
        .in_flit_i(in_flit_i), .out_vld_o(out_vld_o), .out_flit_o(out_flit_o),
        .in_vld_o(in_vld_o), .in_flit_o(in_flit_o));

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [W-1:0] mq[$];
    int mwait = 0;
    logic [7:0] mlfsr = 8'hA5;

    task automatic check(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        int n;
        logic [N-1:0] e_ovld, e_ivld;
        logic [N*W-1:0] e_iflit;
        logic redir, pop, pushv;
        logic [W-1:0] pdata;
        n = mq.size();
        e_ovld = out_vld_i; e_ivld = in_vld_i; e_iflit = in_flit_i;
        redir = 0; pop = 0; pushv = 0; pdata = '0;
        if (n > 0 && (&in_vld_i) && mwait >= T) begin
            for (int k = 0; k < N; k++) begin
                int j;
                j = (int'(mlfsr) % N + k) % N;
                if (!redir && !in_gold_i[j]) begin
                    redir = 1; pop = 1; pushv = 1;
                    pdata = in_flit_i[j*W +: W];
                    e_iflit[j*W +: W] = mq[0];
                end
            end
        end else if (n > 0 && !(&in_vld_i)) begin
            for (int j = 0; j < N; j++) begin
                if (!pop && !in_vld_i[j]) begin
                    pop = 1;
                    e_ivld[j] = 1'b1;
                    e_iflit[j*W +: W] = mq[0];
                end
            end
        end
        if (!redir && n < D) begin
            for (int i = 0; i < N; i++) begin
                if (!pushv && out_vld_i[i] && out_defl_i[i] && !out_gold_i[i]) begin
                    pushv = 1;
                    e_ovld[i] = 1'b0;
                    pdata = out_flit_i[i*W +: W];
                end
            end
        end
        #1;
        check({tag, " out_vld"}, (N*W)'(out_vld_o), (N*W)'(e_ovld));
        check({tag, " out_flit"}, out_flit_o, out_flit_i);
        check({tag, " in_vld"}, (N*W)'(in_vld_o), (N*W)'(e_ivld));
        check({tag, " in_flit"}, in_flit_o, e_iflit);
        if (pop) void'(mq.pop_front());
        if (pushv) mq.push_back(pdata);
        mwait = (pop || n == 0) ? 0 : ((mwait < T) ? mwait + 1 : T);
        mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rnd_flits();
        for (int i = 0; i < N; i++) begin
            out_flit_i[i*W +: W] = W'($urandom);
            in_flit_i[i*W +: W]  = W'($urandom);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rnd_flits();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: empty after reset, pass-through with traffic present
        out_vld_i = 4'b1111; out_defl_i = '0; in_vld_i = 4'b1010;
        step("R9 reset pass");

        // R1: lowest-index deflected lane captured; R5 lowest empty slot refilled
        rnd_flits(); out_defl_i = 4'b1100; in_vld_i = 4'b1111;
        step("R1 lowest lane");
        rnd_flits(); out_defl_i = '0; in_vld_i = 4'b1001;
        step("R5 reinject");

        // R3: golden deflected lane skipped
        rnd_flits(); out_defl_i = 4'b0011; out_gold_i = 4'b0001; in_vld_i = 4'b1111;
        step("R3 golden skipped");
        rnd_flits(); out_defl_i = 4'b1111; out_gold_i = 4'b1111;
        step("R3 all golden");
        out_gold_i = '0; out_defl_i = '0; in_vld_i = '0;
        repeat (3) begin rnd_flits(); step("R5 drain"); end

        // R2: fill with all-golden full slots (no swap possible), then no capture
        in_vld_i = 4'b1111; in_gold_i = 4'b1111; out_defl_i = 4'b1111;
        repeat (6) begin rnd_flits(); step("R2 fill"); end
        out_defl_i = '0;
        repeat (2) begin rnd_flits(); step("R6 saturate"); end
        // R4: drain in order
        in_vld_i = 4'b0111; in_gold_i = '0;
        repeat (5) begin rnd_flits(); step("R4 order"); end

        // R7/R8: swaps with golden slots around the start point
        for (int r = 0; r < 8; r++) begin
            rnd_flits();
            in_vld_i = 4'b1111; in_gold_i = 4'(r * 5) & 4'b0111;
            out_defl_i = 4'b0100;
            step("R7 load");
            out_defl_i = '0;
            repeat (4) begin rnd_flits(); step("R7 R8 swap"); end
            in_vld_i = '0;
            repeat (2) begin rnd_flits(); step("R7 drain"); end
        end

        // R1..R8 random mix
        for (int c = 0; c < 3000; c++) begin
            rnd_flits();
            out_vld_i  = N'($urandom);
            out_defl_i = N'($urandom);
            out_gold_i = N'($urandom) & N'($urandom) & N'($urandom);
            in_vld_i   = N'($urandom) | N'($urandom) | N'($urandom);
            in_gold_i  = N'($urandom) & N'($urandom) & N'($urandom);
            step("R4 R6 R8 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule